// File: doc/BRIEF.md
# Dual-Core Mailbox SRAM with AHB-Lite Slave Port

This block places a word-organised on-chip SRAM behind an AHB-Lite slave port, so that two processor cores sharing one bus can trade data through it. A common use is a flag word that one core sets after filling a buffer and the other core clears after draining it. Each bus transfer completes on its own, so every access to that flag is atomic. The block answers only to a fixed, aligned address window. An access outside that window, a misaligned access or an oversized access gets an AHB error response.

Writes complete with no wait state. The write data is taken in the data phase and stored at the end of that phase. Reads insert exactly one wait state, and the data then comes from a registered read port on a single-port array, a shape that maps onto block RAM. The implemented depth is a parameter. The offset inside the window wraps modulo that depth, so a small array can stand in for the full window.

Top module: `shmem_ahb_slave`

## Requirements
- R1: After a synchronous reset, `hreadyout` is 1 and `hresp` is 0.
- R2: A NONSEQ or SEQ transfer whose address falls outside the window [BASE, BASE+WIN_BYTES) receives an ERROR response. With the defaults the window is 0xA0000000 to 0xA01FFFFF.
- R3: A legal write completes with no wait state: in its data phase `hreadyout` is 1 and `hresp` is 0.
- R4: A legal read holds `hreadyout` low for exactly one data-phase cycle with `hresp` 0. It then raises `hreadyout` with the read data on `hrdata`.
- R5: Writes are little-endian. Byte k of the word is `hwdata[8k+7:8k]`. HSIZE 0, 1 and 2 (byte, halfword, word) together with `haddr[1:0]` select the byte lanes written. Lanes that are not selected keep their old contents.
- R6: A read of any legal size returns the whole addressed word on `hrdata`, and the master picks its own lanes.
- R7: A read issued in the address phase that overlaps a write's data phase returns the newly written value, including when both target the same word.
- R8: A halfword at an odd address, a word whose `haddr[1:0]` is not 0, and any HSIZE above 2 all receive an ERROR response.
- R9: An ERROR response lasts two cycles. In the first, `hreadyout` is 0 and `hresp` is 1. In the second, `hreadyout` is 1 and `hresp` is 1. An erroring write leaves memory unchanged.
- R10: IDLE (HTRANS 0) and BUSY (HTRANS 1) transfers get a zero-wait OKAY and do not touch memory.
- R11: The array holds DEPTH words. The word used is ((haddr-BASE)/4) mod DEPTH, so addresses DEPTH*4 bytes apart alias.
- R12: No transfer is accepted while `hsel` is 0 or `hready_in` is 0. Such a cycle leaves memory unchanged and gives a zero-wait OKAY.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| hsel | input | 1 | Slave select |
| haddr | input | ADDR_W | Byte address, address phase |
| htrans | input | 2 | Transfer type: 0 IDLE, 1 BUSY, 2 NONSEQ, 3 SEQ |
| hwrite | input | 1 | 1 for write, 0 for read |
| hsize | input | 3 | Transfer size, log2 of bytes |
| hwdata | input | DATA_W | Write data, data phase |
| hready_in | input | 1 | Bus-level ready; a new address phase is taken only when high |
| hreadyout | output | 1 | Slave ready for the current data phase |
| hresp | output | 1 | 0 OKAY, 1 ERROR |
| hrdata | output | DATA_W | Read data, valid when a read's data phase completes |

## Verification
The checker watches the response handshake on every cycle. It confirms that a read is followed by exactly one low-ready OKAY cycle, that a write never stalls unless it errors, and that each error is a clean two-cycle pair. It also confirms that IDLE, BUSY, deselected and stalled cycles leave the port ready with an OKAY. Whether bytes land in the right lanes, whether errored writes and ignored cycles leave memory untouched, whether a read that directly follows a write sees the new data, and how addresses alias modulo the depth are all matters of data content. Only the bench's transfers, each checked against a value read back, can show these.

// File: rtl/shmem_pkg.sv
package shmem_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_WR,
    PH_RD_WAIT,
    PH_RD_DATA,
    PH_ERR_1,
    PH_ERR_2
  } phase_e;

  localparam logic [1:0] TR_IDLE   = 2'd0;
  localparam logic [1:0] TR_BUSY   = 2'd1;
  localparam logic [1:0] TR_NONSEQ = 2'd2;
  localparam logic [1:0] TR_SEQ    = 2'd3;

endpackage

// File: rtl/shmem_decode.sv
module shmem_decode #(
  parameter int          ADDR_W    = 32,
  parameter int          DATA_W    = 32,
  parameter int          DEPTH     = 256,
  parameter logic [31:0] BASE      = 32'hA000_0000,
  parameter logic [31:0] WIN_BYTES = 32'h0020_0000,
  localparam int         BYTES     = DATA_W / 8,
  localparam int         OFF_W     = $clog2(BYTES),
  localparam int         IDX_W     = $clog2(DEPTH)
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [2:0]        size,
  output logic              legal,
  output logic [IDX_W-1:0]  idx,
  output logic [BYTES-1:0]  lanes
);

  logic [ADDR_W:0]   ext_addr;
  logic [ADDR_W:0]   offset;
  logic              in_win;
  logic              size_ok;
  logic              aligned;
  logic [OFF_W-1:0]  byte_off;
  logic [OFF_W-1:0]  align_mask;

  assign ext_addr = {1'b0, addr};
  assign offset   = ext_addr - (ADDR_W+1)'(BASE);
  assign in_win   = (ext_addr >= (ADDR_W+1)'(BASE)) &&
                    (offset < (ADDR_W+1)'(WIN_BYTES));

  assign byte_off   = addr[OFF_W-1:0];
  assign size_ok    = (int'(size) <= OFF_W);
  assign align_mask = size_ok ? OFF_W'((1 << size) - 1) : '1;
  assign aligned    = (byte_off & align_mask) == '0;

  assign legal = in_win && size_ok && aligned;
  assign idx   = offset[OFF_W +: IDX_W];

  // Lane k belongs to the transfer when it sits in the same size-aligned
  // group as the addressed byte.
  genvar k;
  generate
    for (k = 0; k < BYTES; k++) begin : g_lane
      assign lanes[k] = size_ok &&
                        ((OFF_W'(k) >> size) == (byte_off >> size));
    end
  endgenerate

endmodule

// File: rtl/shmem_ctrl.sv
module shmem_ctrl
  import shmem_pkg::*;
#(
  parameter int  DATA_W = 32,
  parameter int  DEPTH  = 256,
  localparam int BYTES  = DATA_W / 8,
  localparam int IDX_W  = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             is_write,
  input  logic             legal,
  input  logic [IDX_W-1:0] a_idx,
  input  logic [BYTES-1:0] a_lanes,
  output logic             ready_q,
  output logic             resp_q,
  output logic             mem_we,
  output logic             mem_re,
  output logic [IDX_W-1:0] dp_idx,
  output logic [BYTES-1:0] dp_lanes
);

  phase_e phase, phase_nxt;

  always_comb begin
    phase_nxt = PH_IDLE;
    case (phase)
      PH_RD_WAIT: phase_nxt = PH_RD_DATA;
      PH_ERR_1:   phase_nxt = PH_ERR_2;
      default: begin
        if (start) begin
          if (!legal)        phase_nxt = PH_ERR_1;
          else if (is_write) phase_nxt = PH_WR;
          else               phase_nxt = PH_RD_WAIT;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      ready_q  <= 1'b1;
      resp_q   <= 1'b0;
      dp_idx   <= '0;
      dp_lanes <= '0;
    end else begin
      phase   <= phase_nxt;
      ready_q <= !(phase_nxt == PH_RD_WAIT || phase_nxt == PH_ERR_1);
      resp_q  <= (phase_nxt == PH_ERR_1 || phase_nxt == PH_ERR_2);
      if (start && phase != PH_RD_WAIT && phase != PH_ERR_1) begin
        dp_idx   <= a_idx;
        dp_lanes <= a_lanes;
      end
    end
  end

  assign mem_we = (phase == PH_WR);
  assign mem_re = (phase == PH_RD_WAIT);

endmodule

// File: rtl/shmem_array.sv
module shmem_array #(
  parameter int  DATA_W = 32,
  parameter int  DEPTH  = 256,
  localparam int BYTES  = DATA_W / 8,
  localparam int IDX_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [BYTES-1:0]  be,
  input  logic              re,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] store [DEPTH];

  // Single port, byte-enabled write, registered read.
  always_ff @(posedge clk) begin
    for (int b = 0; b < BYTES; b++) begin
      if (we && be[b]) store[idx][b*8 +: 8] <= wdata[b*8 +: 8];
    end
    if (re) rdata <= store[idx];
  end

endmodule

// File: rtl/shmem_ahb_slave.sv
module shmem_ahb_slave
  import shmem_pkg::*;
#(
  parameter int          ADDR_W    = 32,
  parameter int          DATA_W    = 32,
  parameter int          DEPTH     = 256,
  parameter logic [31:0] BASE      = 32'hA000_0000,
  parameter logic [31:0] WIN_BYTES = 32'h0020_0000,
  localparam int         BYTES     = DATA_W / 8,
  localparam int         IDX_W     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hsel,
  input  logic [ADDR_W-1:0] haddr,
  input  logic [1:0]        htrans,
  input  logic              hwrite,
  input  logic [2:0]        hsize,
  input  logic [DATA_W-1:0] hwdata,
  input  logic              hready_in,
  output logic              hreadyout,
  output logic              hresp,
  output logic [DATA_W-1:0] hrdata
);

  logic             start;
  logic             legal;
  logic [IDX_W-1:0] a_idx;
  logic [BYTES-1:0] a_lanes;
  logic             mem_we;
  logic             mem_re;
  logic [IDX_W-1:0] dp_idx;
  logic [BYTES-1:0] dp_lanes;

  assign start = hsel && hready_in &&
                 (htrans == TR_NONSEQ || htrans == TR_SEQ);

  shmem_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH),
    .BASE(BASE), .WIN_BYTES(WIN_BYTES)
  ) u_dec (
    .addr (haddr),
    .size (hsize),
    .legal(legal),
    .idx  (a_idx),
    .lanes(a_lanes)
  );

  shmem_ctrl #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .is_write(hwrite),
    .legal   (legal),
    .a_idx   (a_idx),
    .a_lanes (a_lanes),
    .ready_q (hreadyout),
    .resp_q  (hresp),
    .mem_we  (mem_we),
    .mem_re  (mem_re),
    .dp_idx  (dp_idx),
    .dp_lanes(dp_lanes)
  );

  shmem_array #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
    .clk  (clk),
    .we   (mem_we),
    .be   (dp_lanes),
    .re   (mem_re),
    .idx  (dp_idx),
    .wdata(hwdata),
    .rdata(hrdata)
  );

endmodule

// File: rtl/shmem_ahb_chk.sv
module shmem_ahb_chk (
  input logic       clk,
  input logic       rst,
  input logic       hsel,
  input logic [1:0] htrans,
  input logic       hwrite,
  input logic       hready_in,
  input logic       hreadyout,
  input logic       hresp
);

  logic accept;
  assign accept = hsel && hready_in && htrans[1];

  // R3
  wr_nowait_chk: assert property (@(posedge clk) disable iff (rst)
    accept && hwrite |=> (hreadyout != hresp));

  // R4
  rd_wait_chk: assert property (@(posedge clk) disable iff (rst)
    accept && !hwrite |=> !hreadyout);

  // R4
  rd_one_wait_chk: assert property (@(posedge clk) disable iff (rst)
    !hreadyout && !hresp |=> hreadyout && !hresp);

  // R9
  err_second_chk: assert property (@(posedge clk) disable iff (rst)
    !hreadyout && hresp |=> hreadyout && hresp);

  // R9
  err_first_chk: assert property (@(posedge clk) disable iff (rst)
    hreadyout && hresp |-> $past(!hreadyout && hresp));

  // R10
  idle_okay_chk: assert property (@(posedge clk) disable iff (rst)
    hsel && hready_in && !htrans[1] |=> hreadyout && !hresp);

  // R12
  no_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (!hsel || !hready_in) && hreadyout |=> hreadyout && !hresp);

endmodule

bind shmem_ahb_slave shmem_ahb_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .hsel     (hsel),
  .htrans   (htrans),
  .hwrite   (hwrite),
  .hready_in(hready_in),
  .hreadyout(hreadyout),
  .hresp    (hresp)
);

// File: tb/sim_shmem_ahb_slave.sv
module sim_shmem_ahb_slave;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hsel = 1'b0;
  logic [31:0] haddr = '0;
  logic [1:0]  htrans = 2'd0;
  logic        hwrite = 1'b0;
  logic [2:0]  hsize = 3'd2;
  logic [31:0] hwdata = '0;
  logic        stall = 1'b0;
  logic        hready_in;
  logic        hreadyout;
  logic        hresp;
  logic [31:0] hrdata;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  assign hready_in = hreadyout && !stall;

  shmem_ahb_slave u0 (
    .clk(clk), .rst(rst), .hsel(hsel), .haddr(haddr), .htrans(htrans),
    .hwrite(hwrite), .hsize(hsize), .hwdata(hwdata), .hready_in(hready_in),
    .hreadyout(hreadyout), .hresp(hresp), .hrdata(hrdata)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 20000 && !done) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog actual=%0d expected=<20000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req,
                     input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One isolated transfer; returns wait count, final response and read data.
  task automatic xfer(input bit wr, input logic [2:0] sz,
                      input logic [31:0] a, input logic [31:0] wd,
                      output int waits, output bit err,
                      output logic [31:0] rd);
    @(negedge clk);
    hsel = 1'b1; htrans = 2'd2; hwrite = wr; hsize = sz; haddr = a;
    @(negedge clk);
    hsel = 1'b0; htrans = 2'd0; hwdata = wd;
    waits = 0;
    while (!hreadyout && waits < 4) begin
      waits++;
      @(negedge clk);
    end
    err = hresp;
    rd  = hrdata;
  endtask

  // {write, size, addr, wdata, expect_error, expect_rdata}
  localparam int NV = 18;
  localparam logic [100:0] VEC [NV] = '{
    {1'b1, 3'd2, 32'hA000_0000, 32'h1122_3344, 1'b0, 32'h0},          // R3
    {1'b0, 3'd2, 32'hA000_0000, 32'h0,         1'b0, 32'h1122_3344},  // R4
    {1'b1, 3'd0, 32'hA000_0001, 32'h0000_AA00, 1'b0, 32'h0},          // R5 byte lane1
    {1'b0, 3'd2, 32'hA000_0000, 32'h0,         1'b0, 32'h1122_AA44},  // R5
    {1'b1, 3'd1, 32'hA000_0002, 32'hBEEF_0000, 1'b0, 32'h0},          // R5 upper half
    {1'b0, 3'd0, 32'hA000_0003, 32'h0,         1'b0, 32'hBEEF_AA44},  // R6 byte read
    {1'b1, 3'd2, 32'hA000_0004, 32'hCAFE_F00D, 1'b0, 32'h0},
    {1'b1, 3'd1, 32'hA000_0005, 32'h1111_1111, 1'b1, 32'h0},          // R8 odd half
    {1'b1, 3'd2, 32'hA000_0006, 32'h2222_2222, 1'b1, 32'h0},          // R8 word off
    {1'b0, 3'd2, 32'hA000_0004, 32'h0,         1'b0, 32'hCAFE_F00D},  // R9 unchanged
    {1'b1, 3'd2, 32'hA020_0000, 32'h3333_3333, 1'b1, 32'h0},          // R2 above
    {1'b0, 3'd2, 32'h9FFF_FFFC, 32'h0,         1'b1, 32'h0},          // R2 below
    {1'b1, 3'd2, 32'hA01F_FFFC, 32'h5A5A_5A5A, 1'b0, 32'h0},          // R2 top word
    {1'b0, 3'd2, 32'hA000_03FC, 32'h0,         1'b0, 32'h5A5A_5A5A},  // R11 alias
    {1'b1, 3'd3, 32'hA000_0008, 32'h4444_4444, 1'b1, 32'h0},          // R8 size 3
    {1'b1, 3'd2, 32'hA000_0010, 32'h0000_0000, 1'b0, 32'h0},
    {1'b1, 3'd0, 32'hA000_0013, 32'h9900_0000, 1'b0, 32'h0},          // R5 lane3
    {1'b0, 3'd1, 32'hA000_0012, 32'h0,         1'b0, 32'h9900_0000}   // R6 half read
  };

  initial begin
    int w;
    bit e;
    logic [31:0] r;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk(hreadyout == 1'b1, "R1 hreadyout", 32'(hreadyout), 32'd1);
    chk(hresp == 1'b0, "R1 hresp", 32'(hresp), 32'd0);

    for (int i = 0; i < NV; i++) begin
      logic        v_wr;
      logic [2:0]  v_sz;
      logic [31:0] v_a, v_wd, v_rd;
      logic        v_err;
      int          exp_w;
      {v_wr, v_sz, v_a, v_wd, v_err, v_rd} = VEC[i];
      xfer(v_wr, v_sz, v_a, v_wd, w, e, r);
      exp_w = (v_err || !v_wr) ? 1 : 0;
      chk(e == v_err, v_err ? "R2/R8/R9 error resp" : "R3/R4 okay resp",
          32'(e), 32'(v_err));
      chk(w == exp_w, "R3/R4/R9 wait count", 32'(w), 32'(exp_w));
      if (!v_wr && !v_err)
        chk(r == v_rd, "R4/R5/R6/R11 read data", r, v_rd);
    end

    // R9: first cycle of an error response
    @(negedge clk);
    hsel = 1'b1; htrans = 2'd2; hwrite = 1'b0; hsize = 3'd2; haddr = 32'hB000_0000;
    @(negedge clk);
    hsel = 1'b0; htrans = 2'd0;
    chk(!hreadyout && hresp, "R9 error cycle 1", {30'd0, hreadyout, hresp}, 32'd1);
    @(negedge clk);
    chk(hreadyout && hresp, "R9 error cycle 2", {30'd0, hreadyout, hresp}, 32'd3);

    // R7: read pipelined straight behind a byte write to the same word
    xfer(1'b1, 3'd2, 32'hA000_0020, 32'h0, w, e, r);
    @(negedge clk);
    hsel = 1'b1; htrans = 2'd2; hwrite = 1'b1; hsize = 3'd0; haddr = 32'hA000_0021;
    @(negedge clk);
    hwdata = 32'h0000_AB00;
    hwrite = 1'b0; hsize = 3'd2; haddr = 32'hA000_0020;
    chk(hreadyout && !hresp, "R3 pipelined write ready", 32'(hreadyout), 32'd1);
    @(negedge clk);
    hsel = 1'b0; htrans = 2'd0;
    chk(!hreadyout, "R4 pipelined read wait", 32'(hreadyout), 32'd0);
    @(negedge clk);
    chk(hreadyout && !hresp, "R4 pipelined read done", 32'(hreadyout), 32'd1);
    chk(hrdata == 32'h0000_AB00, "R7 read after write", hrdata, 32'h0000_AB00);

    // R10 / R12: ignored cycles leave a known word alone
    xfer(1'b1, 3'd2, 32'hA000_0030, 32'h1111_1111, w, e, r);
    @(negedge clk);
    hsel = 1'b1; htrans = 2'd0; hwrite = 1'b1; hsize = 3'd2; haddr = 32'hA000_0030;
    @(negedge clk);
    hwdata = 32'hDEAD_0001; htrans = 2'd1;
    chk(hreadyout && !hresp, "R10 idle okay", 32'(hreadyout), 32'd1);
    @(negedge clk);
    hwdata = 32'hDEAD_0002; hsel = 1'b0; htrans = 2'd2;
    chk(hreadyout && !hresp, "R10 busy okay", 32'(hreadyout), 32'd1);
    @(negedge clk);
    hwdata = 32'hDEAD_0003; hsel = 1'b1; stall = 1'b1;
    chk(hreadyout && !hresp, "R12 deselected okay", 32'(hreadyout), 32'd1);
    @(negedge clk);
    hwdata = 32'hDEAD_0004; hsel = 1'b0; htrans = 2'd0; stall = 1'b0;
    chk(hreadyout && !hresp, "R12 stalled okay", 32'(hreadyout), 32'd1);
    xfer(1'b0, 3'd2, 32'hA000_0030, 32'h0, w, e, r);
    chk(r == 32'h1111_1111, "R10/R12 memory untouched", r, 32'h1111_1111);

    // R1: reset in the middle of a read wait
    @(negedge clk);
    hsel = 1'b1; htrans = 2'd2; hwrite = 1'b0; haddr = 32'hA000_0030;
    @(negedge clk);
    hsel = 1'b0; htrans = 2'd0; rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(hreadyout && !hresp, "R1 reset mid-read", 32'(hreadyout), 32'd1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule